// File: doc/BRIEF.md
# Streaming Pixel Repacker

This block converts a wide frame-buffer stream into a byte-serial display stream. Every 64-bit input word carries two 32-bit pixels, each made of four 8-bit symbols. The word is narrowed to two 32-bit beats, and each beat loses its padding byte to leave a 24-bit colour triple. That triple is then serialised into three 8-bit output beats, so one input word produces six output bytes.

Both sides use a valid/ready handshake, and every internal stage can be stalled by the stage after it. Packet delimiters travel with the data. The start marker of a word lands on the first byte that word produces. The end marker lands on the last byte that word produces.

Top module: `pix_repack`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each accepted input word yields exactly six output bytes. No byte is lost or repeated under any pattern of `out_ready`.
- R3: The pixel in `in_data[63:32]` is emitted before the pixel in `in_data[31:0]`.
- R4: Bits [31:24] of each 32-bit pixel are discarded and have no effect on any output byte.
- R5: Within a pixel, bits [23:16] (red) are emitted first, then [15:8] (green), then [7:0] (blue).
- R6: `out_sop` is 1 only on the first of the six bytes of a word accepted with `in_sop`=1. `out_eop` is 1 only on the sixth byte of a word accepted with `in_eop`=1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values into the next cycle.
- R8: `in_ready` is 0 while the input stage still holds unsent symbols of its current word. It may be 1 only in the cycle where the last of those symbols is handed downstream.
- R9: With `out_ready` held at 1 and input always valid, output bytes leave on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 64 | Two pixels, first pixel in the upper half |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Colour byte |
| out_sop | output | 1 | Byte starts a packet |
| out_eop | output | 1 | Byte ends a packet |

## Verification
The assertions check several properties on every cycle. Each stage holds its output under a stall. The input stage reloads only on the same cycle its last chunk is handed on. The trimming stage forwards exactly the low 24 bits of the pixel it took. The packet markers appear only at byte positions 0 and 5 of each word's six-byte group.

Only the bench scenarios can show the remaining properties. These are the actual byte values and their ordering across pixels and channels, and that nothing is lost or duplicated over long runs with irregular backpressure. They also cover that input acceptance stops during a sustained stall and that output runs gap-free at full rate.

// File: rtl/pix_repack_pkg.sv
package pix_repack_pkg;

  localparam int unsigned SYM_W_DEF     = 8;
  localparam int unsigned WORD_SYMS_DEF = 8;
  localparam int unsigned PIX_SYMS_DEF  = 4;
  localparam int unsigned RGB_SYMS_DEF  = 3;

  // Number of narrow beats a wide beat splits into.
  function automatic int unsigned chunk_count(int unsigned in_syms, int unsigned out_syms);
    return in_syms / out_syms;
  endfunction

  // Index width for a chunk counter; never zero.
  function automatic int unsigned idx_width(int unsigned chunks);
    return (chunks > 1) ? $clog2(chunks) : 1;
  endfunction

  // Output bytes produced by one input word.
  function automatic int unsigned bytes_per_word(int unsigned word_syms, int unsigned pix_syms,
                                                 int unsigned rgb_syms);
    return (word_syms / pix_syms) * rgb_syms;
  endfunction

endpackage

// File: rtl/sym_narrow.sv
module sym_narrow
  import pix_repack_pkg::*;
#(
  parameter int unsigned SYM_W    = 8,
  parameter int unsigned IN_SYMS  = 8,
  parameter int unsigned OUT_SYMS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SYM_W*IN_SYMS-1:0]  in_data,
  input  logic                      in_sop,
  input  logic                      in_eop,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [SYM_W*OUT_SYMS-1:0] out_data,
  output logic                      out_sop,
  output logic                      out_eop
);

  localparam int unsigned IN_W   = SYM_W * IN_SYMS;
  localparam int unsigned OUT_W  = SYM_W * OUT_SYMS;
  localparam int unsigned CHUNKS = chunk_count(IN_SYMS, OUT_SYMS);
  localparam int unsigned IDX_W  = idx_width(CHUNKS);
  localparam int unsigned CNT_W  = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNKS - 1);

  logic [IN_W-1:0]  word_q;
  logic             full_q;
  logic [IDX_W-1:0] idx_q;
  logic             sop_q;
  logic             eop_q;
  logic [CNT_W-1:0] sent_q;

  // Named events for assertions
  logic in_fire;
  logic out_fire;
  logic last_chunk;

  logic [OUT_W-1:0] chunk [CHUNKS];

  // Most significant chunk leaves first
  for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
    assign chunk[g] = word_q[IN_W-1-g*OUT_W -: OUT_W];
  end

  assign last_chunk = (idx_q == LAST_IDX);
  assign out_valid  = full_q;
  assign out_fire   = full_q && out_ready;
  assign in_ready   = !full_q || (last_chunk && out_ready);
  assign in_fire    = in_valid && in_ready;
  assign out_sop    = sop_q && (idx_q == '0);
  assign out_eop    = eop_q && last_chunk;

  always_comb begin
    out_data = '0;
    for (int i = 0; i < CHUNKS; i++) begin
      if (idx_q == IDX_W'(i)) out_data = chunk[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
    end else if (in_fire) begin
      full_q <= 1'b1;
      idx_q  <= '0;
      sop_q  <= in_sop;
      eop_q  <= in_eop;
    end else if (out_fire) begin
      if (last_chunk) begin
        full_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) word_q <= in_data;
  end

  // Chunks handed on since the last load, kept for the checks below
  always_ff @(posedge clk) begin
    if (!rst_n)        sent_q <= '0;
    else if (in_fire)  sent_q <= '0;
    else if (out_fire) sent_q <= sent_q + CNT_W'(1);
  end

  AST_NARROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R7

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && full_q |-> out_fire && (sent_q == CNT_W'(CHUNKS - 1))); // R8

  AST_NO_EXTRA_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> sent_q < CNT_W'(CHUNKS)); // R2

endmodule

// File: rtl/px_trim.sv
module px_trim #(
  parameter int unsigned SYM_W     = 8,
  parameter int unsigned IN_SYMS   = 4,
  parameter int unsigned KEEP_SYMS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [SYM_W*IN_SYMS-1:0]   in_data,
  input  logic                       in_sop,
  input  logic                       in_eop,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [SYM_W*KEEP_SYMS-1:0] out_data,
  output logic                       out_sop,
  output logic                       out_eop
);

  localparam int unsigned IN_W   = SYM_W * IN_SYMS;
  localparam int unsigned KEEP_W = SYM_W * KEEP_SYMS;

  logic              vld_q;
  logic [KEEP_W-1:0] rgb_q;
  logic              sop_q;
  logic              eop_q;
  logic              in_fire;

  // Upper padding symbols are dropped here
  logic unused_pad;
  assign unused_pad = ^in_data[IN_W-1:KEEP_W];

  assign in_ready  = !vld_q || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign out_valid = vld_q;
  assign out_data  = rgb_q;
  assign out_sop   = sop_q;
  assign out_eop   = eop_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        vld_q <= 1'b0;
    else if (in_fire)  vld_q <= 1'b1;
    else if (out_ready) vld_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      rgb_q <= in_data[KEEP_W-1:0];
      sop_q <= in_sop;
      eop_q <= in_eop;
    end
  end

  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R7

  AST_TRIM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid && (out_data == $past(in_data[KEEP_W-1:0]))); // R4

endmodule

// File: rtl/pix_repack.sv
module pix_repack
  import pix_repack_pkg::*;
#(
  parameter int unsigned SYM_W     = SYM_W_DEF,
  parameter int unsigned WORD_SYMS = WORD_SYMS_DEF,
  parameter int unsigned PIX_SYMS  = PIX_SYMS_DEF,
  parameter int unsigned RGB_SYMS  = RGB_SYMS_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [SYM_W*WORD_SYMS-1:0] in_data,
  input  logic                       in_sop,
  input  logic                       in_eop,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [SYM_W-1:0]           out_data,
  output logic                       out_sop,
  output logic                       out_eop
);

  localparam int unsigned PIX_W   = SYM_W * PIX_SYMS;
  localparam int unsigned RGB_W   = SYM_W * RGB_SYMS;
  localparam int unsigned BPW     = bytes_per_word(WORD_SYMS, PIX_SYMS, RGB_SYMS);
  localparam int unsigned PH_W    = idx_width(BPW);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BPW - 1);

  // Word to pixel
  logic             px_valid, px_ready, px_sop, px_eop;
  logic [PIX_W-1:0] px_data;
  // Pixel to colour triple
  logic             rgb_valid, rgb_ready, rgb_sop, rgb_eop;
  logic [RGB_W-1:0] rgb_data;

  sym_narrow #(.SYM_W(SYM_W), .IN_SYMS(WORD_SYMS), .OUT_SYMS(PIX_SYMS)) i_word_split (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(px_valid), .out_ready(px_ready), .out_data(px_data), .out_sop(px_sop), .out_eop(px_eop)
  );

  px_trim #(.SYM_W(SYM_W), .IN_SYMS(PIX_SYMS), .KEEP_SYMS(RGB_SYMS)) i_trim (
    .clk(clk), .rst_n(rst_n),
    .in_valid(px_valid), .in_ready(px_ready), .in_data(px_data), .in_sop(px_sop), .in_eop(px_eop),
    .out_valid(rgb_valid), .out_ready(rgb_ready), .out_data(rgb_data), .out_sop(rgb_sop), .out_eop(rgb_eop)
  );

  sym_narrow #(.SYM_W(SYM_W), .IN_SYMS(RGB_SYMS), .OUT_SYMS(1)) i_byte_ser (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rgb_valid), .in_ready(rgb_ready), .in_data(rgb_data), .in_sop(rgb_sop), .in_eop(rgb_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  // Position of the current output byte within its word's group
  logic            out_fire;
  logic [PH_W-1:0] byte_phase_q;

  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) byte_phase_q <= '0;
    else if (out_fire) byte_phase_q <= (byte_phase_q == PH_LAST) ? '0 : byte_phase_q + PH_W'(1);
  end

  AST_SOP_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> byte_phase_q == '0); // R6

  AST_EOP_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> byte_phase_q == PH_LAST); // R6

  AST_MARK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sop && out_eop)); // R6

endmodule

// File: tb/test_pix_repack.sv
module test_pix_repack;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_sop;
  logic        out_eop;

  always #5 clk = ~clk;

  pix_repack i_pix_repack (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  // {sop, eop, word}; padding bytes [63:56] and [31:24] deliberately noisy (R4)
  localparam logic [65:0] VEC [8] = '{
    {1'b1, 1'b0, 64'hFF11_2233_A544_5566},
    {1'b0, 1'b0, 64'h0077_8899_FFAA_BBCC},
    {1'b0, 1'b1, 64'h5ADD_EEF0_3C01_0203},
    {1'b1, 1'b1, 64'h8010_2030_7F40_5060},
    {1'b1, 1'b0, 64'h00FF_FFFF_0000_0000},
    {1'b0, 1'b0, 64'hFF00_0000_FFFF_FFFF},
    {1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0},
    {1'b0, 1'b1, 64'hC3E7_18A5_69B4_D20F}
  };

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic [9:0] exp_q [$];
  logic [1:0] rdy_mode = 2'd0;
  logic [15:0] lfsr = 16'hACE1;
  logic rate_win = 1'b0;
  int first_cyc = -1;
  int last_cyc  = -1;
  int win_bytes = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected bytes, written from the requirements: upper pixel first (R3),
  // red/green/blue from bits 23:16, 15:8, 7:0 (R5), markers on bytes 0 and 5 (R6)
  function automatic logic [7:0] exp_byte(logic [63:0] w, int k);
    logic [31:0] px;
    px = (k < 3) ? w[63:32] : w[31:0];
    case (k % 3)
      0:       return px[23:16];
      1:       return px[15:8];
      default: return px[7:0];
    endcase
  endfunction

  task automatic expect_word(input logic [65:0] v);
    for (int k = 0; k < 6; k++)
      exp_q.push_back({v[65] && (k == 0), v[64] && (k == 5), exp_byte(v[63:0], k)});
  endtask

  task automatic push(input logic [65:0] v);
    expect_word(v);
    @(negedge clk);
    in_valid = 1'b1;
    in_sop   = v[65];
    in_eop   = v[64];
    in_data  = v[63:0];
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      2'd0:    out_ready <= 1'b1;
      2'd1:    out_ready <= lfsr[0];
      default: out_ready <= 1'b0;
    endcase
  end

  // Output monitor: handshake sampled mid-cycle, completes at next edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected extra byte", int'(out_data), 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check(out_data == e[7:0], "R3/R4/R5 byte value", int'(out_data), int'(e[7:0]));
        check({out_sop, out_eop} == e[9:8], "R6 packet markers", int'({out_sop, out_eop}), int'(e[9:8]));
      end
      if (rate_win) begin
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        win_bytes++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // Table walk at full rate (R9)
    rate_win = 1'b1;
    for (int i = 0; i < 8; i++) push(VEC[i]);
    drain();
    rate_win = 1'b0;
    check(win_bytes == 48, "R2 byte count at full rate", win_bytes, 48);
    check(last_cyc - first_cyc == 47, "R9 gap-free output span", last_cyc - first_cyc, 47);

    // Same table under irregular backpressure (R2, R7)
    rdy_mode = 2'd1;
    for (int i = 0; i < 8; i++) push(VEC[i]);
    drain();
    check(exp_q.size() == 0, "R2 all bytes delivered under backpressure", exp_q.size(), 0);

    // Sustained stall: input must stop being taken, output must hold (R7, R8)
    rdy_mode = 2'd2;
    @(posedge clk);
    @(negedge clk);
    push(VEC[3]);
    push(VEC[6]);
    expect_word(VEC[1]);
    @(negedge clk);
    in_valid = 1'b1;
    in_sop   = VEC[1][65];
    in_eop   = VEC[1][64];
    in_data  = VEC[1][63:0];
    repeat (10) @(negedge clk);
    held = out_data;
    check(in_ready == 1'b0, "R8 in_ready low while symbols buffered", int'(in_ready), 0);
    check(out_valid == 1'b1, "R7 out_valid held during stall", int'(out_valid), 1);
    check(held == exp_q[0][7:0], "R7 first byte presented during stall", int'(held), int'(exp_q[0][7:0]));
    repeat (10) @(negedge clk);
    check(in_ready == 1'b0, "R8 in_ready still low", int'(in_ready), 0);
    check(out_data == held, "R7 out_data stable during stall", int'(out_data), int'(held));
    check(out_sop == 1'b1, "R6 sop on first byte of marked word", int'(out_sop), 1);
    rdy_mode = 2'd1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    drain();
    check(exp_q.size() == 0, "R2 stall scenario drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule